// File: doc/BRIEF.md
# Power Mode Clock and Reset Controller

This block sits at the centre of a chip and decides, for each operating mode, which clock enables and which reset outputs are active. It merges the reset sources (a power-on reset, an external reset pin, a watchdog timeout and a software-written reset bit) into one stretched, synchronously released core and peripheral reset. It also latches two boot strap inputs, but only on hardware resets.

Outside reset, the controller runs a small mode machine with five states: run, debug, wait, stop entry and stop. Each state drives its own set of clock enables, the watchdog enable, the CAN clock enable, the PLL power-down and the PWM output disable. Some of these follow configuration inputs. CAN activity and ungated interrupts pass through synchronizers and wake the chip from wait or stop. Every output that gates a clock comes straight from a flop.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, both reset outputs are low, all clock enables are 1, `wdog_en_o` is 0, `pwm_off_o` is 1, `pll_pd_o` is 0 and both latched strap bits are 0.
- R2: A low on `ext_rst_ni` (through a two-flop synchronizer), or a `wdog_timeout_i` pulse while `wdog_en_o` is 1, asserts both resets. A one-cycle watchdog pulse keeps them low for exactly RST_HOLD cycles. An N-cycle pin pulse keeps them low for N+RST_HOLD-1 cycles.
- R3: A `sw_rst_wr_i` pulse sets `sw_rst_bit_o` for one cycle. The bit clears when the reset sequence starts, and the resets then stay low for RST_HOLD cycles. Writes made while the resets are low are ignored.
- R4: `boot_mode_o` and `mem_if_mode_o` take `boot_strap_i` and `mem_strap_i` when a hardware-caused reset releases. A software reset leaves them unchanged.
- R5: In run mode all clock enables are 1, `wdog_en_o` is 1, and `pll_pd_o` and `pwm_off_o` are 0.
- R6: In debug mode (held by `dbg_req_i` being high) all clocks stay on and `wdog_en_o` is 0, so a watchdog timeout has no effect. `pwm_off_o` equals `cfg_dbg_pwm_off_i`.
- R7: In wait mode the core and memory clock enables are 0 and the peripheral and CAN enables are 1. `wdog_en_o` is the inverse of `cfg_wait_wdog_stop_i` and `pwm_off_o` equals `cfg_wait_pwm_off_i`.
- R8: In stop mode the core and memory enables are 0 and `periph_clk_en_o` equals STOP_KEEP_MASK. `can_clk_en_o` is the inverse of `cfg_stop_can_off_i` and `wdog_en_o` is the inverse of `cfg_stop_wdog_stop_i`. `pwm_off_o` is 1. `pll_pd_o` equals `cfg_pll_shdn_i`, and the PLL is never powered down in any other mode.
- R9: A `stop_req_i` pulse enters stop entry, which keeps the run outputs for STOP_ENT_CYC cycles before the stop outputs appear. A wake seen during entry returns the block to run, and no stop output appears.
- R10: From wait or stop, a high level on `can_wake_i` or `irq_wake_i` restores the run outputs on the third clock edge after it is first sampled.
- R11: In run mode, the requests are served in the order debug, then stop, then wait. A wait or stop request is ignored in any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| wdog_timeout_i | input | 1 | Watchdog timeout pulse |
| sw_rst_wr_i | input | 1 | Write of 1 to the software reset bit |
| boot_strap_i | input | 1 | Boot mode strap |
| mem_strap_i | input | 1 | Memory interface mode strap |
| dbg_req_i | input | 1 | Debug hold request, level |
| wait_req_i | input | 1 | Wait entry request, pulse |
| stop_req_i | input | 1 | Stop entry request, pulse |
| can_wake_i | input | 1 | CAN bus activity, asynchronous |
| irq_wake_i | input | 1 | Ungated interrupt pending, asynchronous |
| cfg_dbg_pwm_off_i | input | 1 | Force PWM off in debug |
| cfg_wait_wdog_stop_i | input | 1 | Stop watchdog in wait |
| cfg_wait_pwm_off_i | input | 1 | Force PWM off in wait |
| cfg_stop_wdog_stop_i | input | 1 | Stop watchdog in stop |
| cfg_stop_can_off_i | input | 1 | Gate CAN clock in stop |
| cfg_pll_shdn_i | input | 1 | Power down PLL in stop |
| core_rst_no | output | 1 | Core reset, active low |
| periph_rst_no | output | 1 | Peripheral reset, active low |
| core_clk_en_o | output | 1 | Core clock enable |
| mem_clk_en_o | output | 1 | Memory clock enable |
| periph_clk_en_o | output | NUM_PERIPH | Peripheral clock enables |
| can_clk_en_o | output | 1 | CAN clock enable |
| wdog_en_o | output | 1 | Watchdog enable |
| pll_pd_o | output | 1 | PLL power-down |
| pwm_off_o | output | 1 | PWM output disable |
| sw_rst_bit_o | output | 1 | Software reset bit readback |
| boot_mode_o | output | 1 | Latched boot mode |
| mem_if_mode_o | output | 1 | Latched memory interface mode |

## Verification
Stop entry and a wake event can fall in the same window. The bench raises a wake input on the same cycle as the stop request, so the synchronized wake arrives while the entry count is still running. Every cycle it then checks that the run outputs stay in place and that the stop gating never appears. A second collision is a software reset write made while a pin reset is already holding the chip. The bench judges it by the readback bit staying 0 and by the reset length matching the pin alone.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    M_RESET, M_RUN, M_DEBUG, M_WAIT, M_STOP_ENT, M_STOP
  } pmc_mode_e;

  typedef struct packed {
    logic core_clk;
    logic mem_clk;
    logic can_clk;
    logic wdog_en;
    logic pll_pd;
    logic pwm_off;
  } pmc_gate_t;

  localparam pmc_gate_t GATE_RST = '{core_clk: 1'b1, mem_clk: 1'b1, can_clk: 1'b1,
                                      wdog_en: 1'b0, pll_pd: 1'b0, pwm_off: 1'b1};
  localparam pmc_gate_t GATE_RUN = '{core_clk: 1'b1, mem_clk: 1'b1, can_clk: 1'b1,
                                      wdog_en: 1'b1, pll_pd: 1'b0, pwm_off: 1'b0};
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pmc_rst_seq.sv
module pmc_rst_seq #(
  parameter int RST_HOLD = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_n_i,
  input  logic wdog_to_i,
  input  logic sw_wr_i,
  input  logic boot_strap_i,
  input  logic mem_strap_i,
  output logic in_rst_o,
  output logic in_rst_d_o,
  output logic sw_bit_o,
  output logic boot_mode_o,
  output logic mem_if_mode_o
);
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(RST_HOLD - 1);

  logic          in_rst_q, in_rst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sw_bit_q, sw_bit_d;
  logic          hw_kind_q;
  logic          boot_q, mem_q;
  logic          src_hw, src, release_w;

  assign src_hw = ~ext_rst_n_i | wdog_to_i;
  assign src    = src_hw | sw_bit_q;

  always_comb begin
    in_rst_d = in_rst_q;
    cnt_d    = cnt_q;
    if (src) begin
      in_rst_d = 1'b1;
      cnt_d    = '0;
    end else if (in_rst_q) begin
      if (cnt_q == CNT_LAST) in_rst_d = 1'b0;
      else                   cnt_d    = cnt_q + 1'b1;
    end
  end

  // bit clears as the sequence starts; writes from a core held in reset are dropped
  always_comb begin
    if (src)                       sw_bit_d = 1'b0;
    else if (sw_wr_i && !in_rst_q) sw_bit_d = 1'b1;
    else                           sw_bit_d = sw_bit_q;
  end

  assign release_w = in_rst_q & ~in_rst_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rst_q  <= 1'b1;
      cnt_q     <= '0;
      sw_bit_q  <= 1'b0;
      hw_kind_q <= 1'b1;
      boot_q    <= 1'b0;
      mem_q     <= 1'b0;
    end else begin
      in_rst_q <= in_rst_d;
      cnt_q    <= cnt_d;
      sw_bit_q <= sw_bit_d;
      if (src_hw)        hw_kind_q <= 1'b1;
      else if (sw_bit_q) hw_kind_q <= 1'b0;
      if (release_w && hw_kind_q) begin
        boot_q <= boot_strap_i;
        mem_q  <= mem_strap_i;
      end
    end
  end

  assign in_rst_o      = in_rst_q;
  assign in_rst_d_o    = in_rst_d;
  assign sw_bit_o      = sw_bit_q;
  assign boot_mode_o   = boot_q;
  assign mem_if_mode_o = mem_q;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int STOP_ENT_CYC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_rst_d_i,
  input  logic      dbg_i,
  input  logic      wait_i,
  input  logic      stop_i,
  input  logic      wake_i,
  output pmc_mode_e mode_d_o
);
  localparam int ECW = $clog2(STOP_ENT_CYC + 1);
  localparam logic [ECW-1:0] ENT_LAST = ECW'(STOP_ENT_CYC - 1);

  pmc_mode_e      mode_q, mode_d;
  logic [ECW-1:0] ecnt_q, ecnt_d;

  always_comb begin
    mode_d = mode_q;
    ecnt_d = ecnt_q;
    if (in_rst_d_i) begin
      mode_d = M_RESET;
      ecnt_d = '0;
    end else begin
      case (mode_q)
        M_RESET: mode_d = M_RUN;
        M_RUN: begin
          if (dbg_i) mode_d = M_DEBUG;
          else if (stop_i) begin
            mode_d = M_STOP_ENT;
            ecnt_d = '0;
          end else if (wait_i) mode_d = M_WAIT;
        end
        M_DEBUG: if (!dbg_i) mode_d = M_RUN;
        M_WAIT:  if (wake_i) mode_d = M_RUN;
        M_STOP_ENT: begin
          if (wake_i)                  mode_d = M_RUN;
          else if (ecnt_q == ENT_LAST) mode_d = M_STOP;
          else                         ecnt_d = ecnt_q + 1'b1;
        end
        M_STOP:  if (wake_i) mode_d = M_RUN;
        default: mode_d = M_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_RESET;
      ecnt_q <= '0;
    end else begin
      mode_q <= mode_d;
      ecnt_q <= ecnt_d;
    end
  end

  assign mode_d_o = mode_d;
endmodule

// File: rtl/pmc_gate_dec.sv
module pmc_gate_dec
  import pmc_pkg::*;
#(
  parameter int                    NUM_PERIPH     = 4,
  parameter logic [NUM_PERIPH-1:0] STOP_KEEP_MASK = NUM_PERIPH'(1)
) (
  input  pmc_mode_e             mode_i,
  input  logic                  cfg_dbg_pwm_off_i,
  input  logic                  cfg_wait_wdog_stop_i,
  input  logic                  cfg_wait_pwm_off_i,
  input  logic                  cfg_stop_wdog_stop_i,
  input  logic                  cfg_stop_can_off_i,
  input  logic                  cfg_pll_shdn_i,
  output pmc_gate_t             gate_o,
  output logic [NUM_PERIPH-1:0] periph_o
);
  always_comb begin
    gate_o = GATE_RUN;
    case (mode_i)
      M_RESET: gate_o = GATE_RST;
      M_DEBUG: begin
        gate_o.wdog_en = 1'b0;
        gate_o.pwm_off = cfg_dbg_pwm_off_i;
      end
      M_WAIT: begin
        gate_o.core_clk = 1'b0;
        gate_o.mem_clk  = 1'b0;
        gate_o.wdog_en  = ~cfg_wait_wdog_stop_i;
        gate_o.pwm_off  = cfg_wait_pwm_off_i;
      end
      M_STOP: begin
        gate_o.core_clk = 1'b0;
        gate_o.mem_clk  = 1'b0;
        gate_o.can_clk  = ~cfg_stop_can_off_i;
        gate_o.wdog_en  = ~cfg_stop_wdog_stop_i;
        gate_o.pll_pd   = cfg_pll_shdn_i;
        gate_o.pwm_off  = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
    assign periph_o[i] = (mode_i == M_STOP) ? STOP_KEEP_MASK[i] : 1'b1;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int                    NUM_PERIPH     = 4,
  parameter logic [NUM_PERIPH-1:0] STOP_KEEP_MASK = NUM_PERIPH'(1),
  parameter int                    RST_HOLD       = 32,
  parameter int                    STOP_ENT_CYC   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ext_rst_ni,
  input  logic                  wdog_timeout_i,
  input  logic                  sw_rst_wr_i,
  input  logic                  boot_strap_i,
  input  logic                  mem_strap_i,
  input  logic                  dbg_req_i,
  input  logic                  wait_req_i,
  input  logic                  stop_req_i,
  input  logic                  can_wake_i,
  input  logic                  irq_wake_i,
  input  logic                  cfg_dbg_pwm_off_i,
  input  logic                  cfg_wait_wdog_stop_i,
  input  logic                  cfg_wait_pwm_off_i,
  input  logic                  cfg_stop_wdog_stop_i,
  input  logic                  cfg_stop_can_off_i,
  input  logic                  cfg_pll_shdn_i,
  output logic                  core_rst_no,
  output logic                  periph_rst_no,
  output logic                  core_clk_en_o,
  output logic                  mem_clk_en_o,
  output logic [NUM_PERIPH-1:0] periph_clk_en_o,
  output logic                  can_clk_en_o,
  output logic                  wdog_en_o,
  output logic                  pll_pd_o,
  output logic                  pwm_off_o,
  output logic                  sw_rst_bit_o,
  output logic                  boot_mode_o,
  output logic                  mem_if_mode_o
);
  logic                  ext_rst_n_s;
  logic [1:0]            wake_s;
  logic                  in_rst_q, in_rst_d;
  pmc_mode_e             mode_d;
  pmc_gate_t             gate_d, gate_q;
  logic [NUM_PERIPH-1:0] periph_d, periph_q;

  pmc_sync #(.W(1), .RST_VAL(1'b0)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_rst_ni), .q_o(ext_rst_n_s)
  );

  pmc_sync #(.W(2), .RST_VAL(2'b00)) u_wake_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({can_wake_i, irq_wake_i}), .q_o(wake_s)
  );

  pmc_rst_seq #(.RST_HOLD(RST_HOLD)) u_rst_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ext_rst_n_i   (ext_rst_n_s),
    .wdog_to_i     (wdog_timeout_i & gate_q.wdog_en),
    .sw_wr_i       (sw_rst_wr_i),
    .boot_strap_i  (boot_strap_i),
    .mem_strap_i   (mem_strap_i),
    .in_rst_o      (in_rst_q),
    .in_rst_d_o    (in_rst_d),
    .sw_bit_o      (sw_rst_bit_o),
    .boot_mode_o   (boot_mode_o),
    .mem_if_mode_o (mem_if_mode_o)
  );

  pmc_mode_fsm #(.STOP_ENT_CYC(STOP_ENT_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_rst_d_i (in_rst_d),
    .dbg_i      (dbg_req_i),
    .wait_i     (wait_req_i),
    .stop_i     (stop_req_i),
    .wake_i     (|wake_s),
    .mode_d_o   (mode_d)
  );

  pmc_gate_dec #(.NUM_PERIPH(NUM_PERIPH), .STOP_KEEP_MASK(STOP_KEEP_MASK)) u_dec (
    .mode_i               (mode_d),
    .cfg_dbg_pwm_off_i    (cfg_dbg_pwm_off_i),
    .cfg_wait_wdog_stop_i (cfg_wait_wdog_stop_i),
    .cfg_wait_pwm_off_i   (cfg_wait_pwm_off_i),
    .cfg_stop_wdog_stop_i (cfg_stop_wdog_stop_i),
    .cfg_stop_can_off_i   (cfg_stop_can_off_i),
    .cfg_pll_shdn_i       (cfg_pll_shdn_i),
    .gate_o               (gate_d),
    .periph_o             (periph_d)
  );

  // enables come from flops only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q   <= GATE_RST;
      periph_q <= '1;
    end else begin
      gate_q   <= gate_d;
      periph_q <= periph_d;
    end
  end

  assign core_rst_no     = ~in_rst_q;
  assign periph_rst_no   = ~in_rst_q;
  assign core_clk_en_o   = gate_q.core_clk;
  assign mem_clk_en_o    = gate_q.mem_clk;
  assign periph_clk_en_o = periph_q;
  assign can_clk_en_o    = gate_q.can_clk;
  assign wdog_en_o       = gate_q.wdog_en;
  assign pll_pd_o        = gate_q.pll_pd;
  assign pwm_off_o       = gate_q.pwm_off;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic core_rst_no,
  input logic core_clk_en_o,
  input logic wdog_en_o,
  input logic pll_pd_o,
  input logic pwm_off_o,
  input logic sw_rst_bit_o,
  input logic boot_mode_o,
  input logic mem_if_mode_o
);
  p_rst_safe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_no |-> (core_clk_en_o && !wdog_en_o && pwm_off_o));

  p_sw_self_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_bit_o |=> !sw_rst_bit_o);

  p_sw_starts_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_bit_o |=> !core_rst_no);

  p_strap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(core_rst_no) |-> ($stable(boot_mode_o) && $stable(mem_if_mode_o)));

  p_pll_stop_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_pd_o |-> (!core_clk_en_o && core_rst_no));
endmodule

bind pwr_mode_ctrl pmc_chk u_pmc_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .core_rst_no   (core_rst_no),
  .core_clk_en_o (core_clk_en_o),
  .wdog_en_o     (wdog_en_o),
  .pll_pd_o      (pll_pd_o),
  .pwm_off_o     (pwm_off_o),
  .sw_rst_bit_o  (sw_rst_bit_o),
  .boot_mode_o   (boot_mode_o),
  .mem_if_mode_o (mem_if_mode_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam logic [NP-1:0] KEEP = 4'b0001;
  localparam int HOLD = 32;
  localparam int ENT = 4;
  localparam int MD_RUN = 0, MD_DBG = 1, MD_WAIT = 2, MD_STOP = 3, MD_RST = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, ext_rst_ni = 1'b1, wdog_timeout_i = 1'b0, sw_rst_wr_i = 1'b0;
  logic boot_strap_i = 1'b1, mem_strap_i = 1'b0;
  logic dbg_req_i = 1'b0, wait_req_i = 1'b0, stop_req_i = 1'b0;
  logic can_wake_i = 1'b0, irq_wake_i = 1'b0;
  logic [5:0] cfg = '0;  // {dbg_pwm, wait_wdog, wait_pwm, stop_wdog, stop_can, pll}
  logic core_rst_no, periph_rst_no, core_clk_en_o, mem_clk_en_o, can_clk_en_o;
  logic wdog_en_o, pll_pd_o, pwm_off_o, sw_rst_bit_o, boot_mode_o, mem_if_mode_o;
  logic [NP-1:0] periph_clk_en_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.NUM_PERIPH(NP), .STOP_KEEP_MASK(KEEP), .RST_HOLD(HOLD),
                  .STOP_ENT_CYC(ENT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni),
    .wdog_timeout_i(wdog_timeout_i), .sw_rst_wr_i(sw_rst_wr_i),
    .boot_strap_i(boot_strap_i), .mem_strap_i(mem_strap_i),
    .dbg_req_i(dbg_req_i), .wait_req_i(wait_req_i), .stop_req_i(stop_req_i),
    .can_wake_i(can_wake_i), .irq_wake_i(irq_wake_i),
    .cfg_dbg_pwm_off_i(cfg[5]), .cfg_wait_wdog_stop_i(cfg[4]),
    .cfg_wait_pwm_off_i(cfg[3]), .cfg_stop_wdog_stop_i(cfg[2]),
    .cfg_stop_can_off_i(cfg[1]), .cfg_pll_shdn_i(cfg[0]),
    .core_rst_no(core_rst_no), .periph_rst_no(periph_rst_no),
    .core_clk_en_o(core_clk_en_o), .mem_clk_en_o(mem_clk_en_o),
    .periph_clk_en_o(periph_clk_en_o), .can_clk_en_o(can_clk_en_o),
    .wdog_en_o(wdog_en_o), .pll_pd_o(pll_pd_o), .pwm_off_o(pwm_off_o),
    .sw_rst_bit_o(sw_rst_bit_o), .boot_mode_o(boot_mode_o),
    .mem_if_mode_o(mem_if_mode_o)
  );

  function automatic logic [NP+5:0] exp_gate(input int m, input logic [5:0] c);
    logic core, mem, can, wdog, pll, pwm;
    logic [NP-1:0] per;
    core = 1; mem = 1; can = 1; wdog = 1; pll = 0; pwm = 0; per = '1;
    case (m)
      MD_RST:  begin wdog = 0; pwm = 1; end
      MD_DBG:  begin wdog = 0; pwm = c[5]; end
      MD_WAIT: begin core = 0; mem = 0; wdog = ~c[4]; pwm = c[3]; end
      MD_STOP: begin core = 0; mem = 0; per = KEEP; can = ~c[1]; wdog = ~c[2];
                     pll = c[0]; pwm = 1; end
      default: ;
    endcase
    return {core, mem, per, can, wdog, pll, pwm};
  endfunction

  function automatic logic [NP+5:0] obs();
    return {core_clk_en_o, mem_clk_en_o, periph_clk_en_o, can_clk_en_o,
            wdog_en_o, pll_pd_o, pwm_off_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // count negedges with reset low over a window; pulse_len cycles of source first
  task automatic rst_window(input int kind, input int pulse_len, output int lows);
    lows = 0;
    if (kind == 0) ext_rst_ni = 1'b0;
    else if (kind == 1) wdog_timeout_i = 1'b1;
    else sw_rst_wr_i = 1'b1;
    for (int i = 0; i < 70; i++) begin
      tick();
      if (i == pulse_len - 1) begin
        ext_rst_ni = 1'b1; wdog_timeout_i = 1'b0; sw_rst_wr_i = 1'b0;
      end
      if (!core_rst_no) lows++;
      if (kind == 2 && i == 0) chk("R3 sw bit set", sw_rst_bit_o, 1);
      if (kind == 2 && i == 1) chk("R3 sw bit cleared", sw_rst_bit_o, 0);
      if (kind == 0 && i == 10) sw_rst_wr_i = 1'b1;
      if (kind == 0 && i == 11) begin
        chk("R3 write in reset ignored", sw_rst_bit_o, 0);
        sw_rst_wr_i = 1'b0;
      end
    end
  endtask

  task automatic wake_and_check(input bit use_can, input string req);
    if (use_can) can_wake_i = 1'b1; else irq_wake_i = 1'b1;
    tick(); tick();
    chk({req, " R10 not yet awake"}, core_clk_en_o, 0);
    tick();
    chk({req, " R10 awake run"}, obs(), exp_gate(MD_RUN, cfg));
    can_wake_i = 1'b0; irq_wake_i = 1'b0;
    repeat (4) tick();
  endtask

  initial begin
    int lows;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    chk("R1 por core reset", core_rst_no, 0);
    chk("R1 por periph reset", periph_rst_no, 0);
    chk("R1 por gating", obs(), exp_gate(MD_RST, cfg));
    chk("R1 por straps", {boot_mode_o, mem_if_mode_o}, 2'b00);
    rst_ni = 1'b1;
    for (int i = 0; i < 100 && !core_rst_no; i++) tick();
    chk("R1 por released", core_rst_no, 1);
    chk("R4 straps latched por", {boot_mode_o, mem_if_mode_o}, 2'b10);
    chk("R5 run gating", obs(), exp_gate(MD_RUN, cfg));

    // software reset keeps straps
    boot_strap_i = 1'b0; mem_strap_i = 1'b1;
    rst_window(2, 1, lows);
    chk("R3 sw reset length", lows, HOLD);
    chk("R4 straps kept after sw reset", {boot_mode_o, mem_if_mode_o}, 2'b10);

    // pin reset, 3 cycles, with a write during reset
    rst_window(0, 3, lows);
    chk("R2 pin reset length", lows, HOLD + 2);
    chk("R4 straps relatched pin", {boot_mode_o, mem_if_mode_o}, 2'b01);
    chk("R5 run after reset", obs(), exp_gate(MD_RUN, cfg));

    rst_window(1, 1, lows);
    chk("R2 wdog reset length", lows, HOLD);

    // debug with pwm off, wdog timeout and wait request ignored
    cfg = 6'b100000;
    dbg_req_i = 1'b1;
    tick();
    chk("R6 debug gating", obs(), exp_gate(MD_DBG, cfg));
    wdog_timeout_i = 1'b1; wait_req_i = 1'b1;
    tick();
    wdog_timeout_i = 1'b0; wait_req_i = 1'b0;
    repeat (3) tick();
    chk("R6 wdog ignored in debug", core_rst_no, 1);
    chk("R11 wait ignored in debug", obs(), exp_gate(MD_DBG, cfg));
    dbg_req_i = 1'b0;
    tick();
    chk("R6 debug exit run", obs(), exp_gate(MD_RUN, cfg));

    // wait with watchdog stopped
    cfg = 6'b011000;
    wait_req_i = 1'b1;
    tick();
    wait_req_i = 1'b0;
    chk("R7 wait gating", obs(), exp_gate(MD_WAIT, cfg));
    wdog_timeout_i = 1'b1; stop_req_i = 1'b1;
    tick();
    wdog_timeout_i = 1'b0; stop_req_i = 1'b0;
    repeat (2) tick();
    chk("R7 wdog ignored in wait", core_rst_no, 1);
    chk("R11 stop ignored in wait", obs(), exp_gate(MD_WAIT, cfg));
    wake_and_check(1'b0, "wait irq");

    // priority: all three at once
    cfg = 6'b000111;
    dbg_req_i = 1'b1; stop_req_i = 1'b1; wait_req_i = 1'b1;
    tick();
    dbg_req_i = 1'b0;
    chk("R11 debug wins", obs(), exp_gate(MD_DBG, cfg));
    tick();
    chk("R11 back to run", obs(), exp_gate(MD_RUN, cfg));
    // stop beats wait
    for (int i = 1; i <= ENT; i++) begin
      tick();
      stop_req_i = 1'b0; wait_req_i = 1'b0;
      chk("R9 entry keeps run", obs(), exp_gate(MD_RUN, cfg));
    end
    tick();
    chk("R8 R11 stop gating", obs(), exp_gate(MD_STOP, cfg));
    wake_and_check(1'b1, "stop can");

    // wake collides with stop entry
    stop_req_i = 1'b1; can_wake_i = 1'b1;
    for (int i = 0; i < 2 * ENT + 2; i++) begin
      tick();
      stop_req_i = 1'b0;
      chk("R9 abort keeps run", obs(), exp_gate(MD_RUN, cfg));
    end
    can_wake_i = 1'b0;
    repeat (4) tick();
    chk("R9 still run after abort", obs(), exp_gate(MD_RUN, cfg));

    // random modes and configurations
    for (int it = 0; it < 60; it++) begin
      int op;
      cfg = 6'($urandom);
      op = $urandom % 3;
      if (op == 0) begin
        dbg_req_i = 1'b1;
        repeat (1 + $urandom % 3) tick();
        chk("R6 rand debug", obs(), exp_gate(MD_DBG, cfg));
        dbg_req_i = 1'b0;
        tick();
        chk("R6 rand debug exit", obs(), exp_gate(MD_RUN, cfg));
      end else if (op == 1) begin
        wait_req_i = 1'b1;
        tick();
        wait_req_i = 1'b0;
        chk("R7 rand wait", obs(), exp_gate(MD_WAIT, cfg));
        repeat ($urandom % 4) tick();
        chk("R7 rand wait hold", obs(), exp_gate(MD_WAIT, cfg));
        wake_and_check(1'($urandom), "rand wait");
      end else begin
        stop_req_i = 1'b1;
        for (int i = 1; i <= ENT; i++) begin
          tick();
          stop_req_i = 1'b0;
        end
        chk("R9 rand last entry cycle", obs(), exp_gate(MD_RUN, cfg));
        tick();
        chk("R8 rand stop", obs(), exp_gate(MD_STOP, cfg));
        wake_and_check(1'($urandom), "rand stop");
      end
      tick();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule